// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Cell with Shared Expander Terms

This block is one logic cell of a complex programmable logic device. Configuration bits decide, for every AND term, which signals take part and whether each enters as its true or its complemented value. Three AND terms are ORed into a sum of products. The sum passes an XOR stage that sets the output polarity or, in an arithmetic mode, folds the first term in as an XOR operand. The result leaves the cell either straight from the logic or through the cell's single flip-flop. That flip-flop has its own product terms for an asynchronous set, an asynchronous clear and an optional private clock.

The AND terms take their literals from an interconnect bus, from expander outputs that neighbouring cells share, from this cell's own expander and from the flip-flop output (the short local feedback path). The cell builds one expander term, an inverted product that it shares with its neighbours and that its own sum terms can also use. This widens a function past three terms or chains products together. The cell output also drives a global feedback line back into the interconnect.

Configuration is written one row at a time through a simple write port that is clocked by the system clock.

Top module: `pterm_macrocell`

## Requirements
- R1: Each configuration row holds one 2-bit code per literal, with literal i at bits [2i+1:2i]. Code 00 leaves the literal out, 01 uses the true value and 10 uses the complemented value. Code 11 makes the term false. Literals are numbered from 0 as follows: the bus bits, then the shared expander inputs, then the cell's own expander output, then the flip-flop output.
- R2: The logic value is the OR of sum-term rows 0, 1 and 2. A sum term that has no literal selected contributes 0.
- R3: Mode bit 0 (mode row, address 7) inverts the logic value.
- R4: When mode bit 3 is set, sum term 0 is removed from the OR. It is XORed with the OR of terms 1 and 2, together with the polarity bit.
- R5: Mode bit 1 selects the flip-flop output for the cell output. When it is clear, the combinational value is selected. With the system clock selected, the flip-flop loads the logic value on each rising edge. The global feedback output always equals the cell output.
- R6: The expander output is the NAND of the row at address 6, and an empty row gives 0. The expander's own literal position is ignored in that row. Sum terms may use the expander output as a literal.
- R7: The flip-flop output is usable as a literal, so the cell can compute from its own registered state.
- R8: The product term at address 3 sets the flip-flop to 1 at once, without waiting for a clock edge. An empty row never sets it.
- R9: The product term at address 4 clears the flip-flop to 0 at once. When both the set and the clear terms are true, the set wins.
- R10: When mode bit 2 is set, the flip-flop is clocked only by rising edges of the product term at address 5, and system clock edges are ignored.
- R11: A row is written from the configuration data on a rising system clock edge when the write enable is high. With the enable low, nothing changes.
- R12: An active-low reset clears every configuration row, the mode bits and the flip-flop. After reset the cell output and the expander output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration row write enable |
| cfgAddr | input | 3 | Row address: 0-2 sum terms, 3 set, 4 clear, 5 clock, 6 expander, 7 mode |
| cfgData | input | 24 | Row contents (mode row uses bits 3:0) |
| busIn | input | 8 | Interconnect bus literals |
| expIn | input | 2 | Expander outputs shared by other cells |
| cellOut | output | 1 | Cell output |
| globalFb | output | 1 | Feedback to the interconnect |
| expOut | output | 1 | This cell's shared expander output |

## Verification
On every system clock edge the assertions check the flip-flop against the set and clear terms and the priority between them. They also check that, with the system clock selected and no set or clear pending, the flip-flop holds the logic value of the previous edge. With the term clock selected and that clock held low, the flip-flop must not move. Literal encoding, the polarity and XOR modes, expander chaining and the ignored own-literal position can only be shown by the bench, and so can the combinational versus registered output choice and the write enable. The bench uses a fixed equation table and random sum-of-products equations checked against its own model for this.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  // Per-literal selection code inside a configuration row
  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_KILL = 2'b11
  } litCode_e;

  // Mode bit positions in the mode row
  localparam int MODE_INVERT_BIT = 0;
  localparam int MODE_REGOUT_BIT = 1;
  localparam int MODE_TERMCLK_BIT = 2;
  localparam int MODE_XORTERM_BIT = 3;
  localparam int MODE_W = 4;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic xorTerm;
    logic termClk;
    logic regOut;
    logic invert;
  } modeCfg_t;

endpackage

// File: rtl/mcell_term.sv
module mcell_term
  import mcell_pkg::*;
#(
  parameter int NUM_LIT = 12
) (
  input  logic [2*NUM_LIT-1:0] row,
  input  logic [NUM_LIT-1:0]   lits,
  output logic                 prod,
  output logic                 used
);

  always_comb begin
    prod = 1'b1;
    used = 1'b0;
    for (int i = 0; i < NUM_LIT; i++) begin
      case (litCode_e'(row[2*i +: 2]))
        LIT_TRUE: begin prod = prod & lits[i];  used = 1'b1; end
        LIT_COMP: begin prod = prod & ~lits[i]; used = 1'b1; end
        LIT_KILL: begin prod = 1'b0;            used = 1'b1; end
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/mcell_cfg.sv
module mcell_cfg
  import mcell_pkg::*;
#(
  parameter int ROW_W     = 24,
  parameter int TERM_ROWS = 7,
  parameter int ADDR_W    = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgWe,
  input  logic [ADDR_W-1:0]              cfgAddr,
  input  logic [ROW_W-1:0]               cfgData,
  output logic [TERM_ROWS-1:0][ROW_W-1:0] termRows,
  output modeCfg_t                       mode
);

  localparam int MODE_ROW = TERM_ROWS;

  logic [TERM_ROWS-1:0][ROW_W-1:0] rowsQ;
  logic [MODE_W-1:0]               modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowsQ <= '0;
      modeQ <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == ADDR_W'(MODE_ROW)) begin
        modeQ <= cfgData[MODE_W-1:0];
      end else begin
        for (int r = 0; r < TERM_ROWS; r++) begin
          if (cfgAddr == ADDR_W'(r)) rowsQ[r] <= cfgData;
        end
      end
    end
  end

  assign termRows     = rowsQ;
  assign mode.invert  = modeQ[MODE_INVERT_BIT];
  assign mode.regOut  = modeQ[MODE_REGOUT_BIT];
  assign mode.termClk = modeQ[MODE_TERMCLK_BIT];
  assign mode.xorTerm = modeQ[MODE_XORTERM_BIT];

endmodule

// File: rtl/mcell_dp.sv
module mcell_dp
  import mcell_pkg::*;
#(
  parameter int NUM_BUS = 8,
  parameter int NUM_EXP = 2,
  parameter int NUM_SUM = 3
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic [NUM_SUM+3:0][2*(NUM_BUS+NUM_EXP+2)-1:0] termRows,
  input  modeCfg_t                                   mode,
  input  logic [NUM_BUS-1:0]                         busIn,
  input  logic [NUM_EXP-1:0]                         expIn,
  output logic                                       cellOut,
  output logic                                       expOut,
  output logic                                       qState,
  output logic                                       dNext,
  output logic                                       presetAct,
  output logic                                       clearAct,
  output logic                                       clkTermAct
);

  localparam int NUM_LIT     = NUM_BUS + NUM_EXP + 2;
  localparam int ROW_W       = 2 * NUM_LIT;
  localparam int TERM_ROWS   = NUM_SUM + 4;
  localparam int PRE_ROW     = NUM_SUM;
  localparam int CLR_ROW     = NUM_SUM + 1;
  localparam int CLK_ROW     = NUM_SUM + 2;
  localparam int EXP_ROW     = NUM_SUM + 3;
  localparam int OWN_EXP_LIT = NUM_BUS + NUM_EXP;

  logic [NUM_LIT-1:0]   litsMain;
  logic [NUM_LIT-1:0]   litsExp;
  logic [ROW_W-1:0]     expRowMasked;
  logic [TERM_ROWS-1:0] termProd;
  logic [TERM_ROWS-1:0] termUsed;
  logic [NUM_SUM-1:0]   sumAct;
  logic [NUM_SUM-1:0]   orIn;
  logic                 expOwn;
  logic                 regClk;

  // Expander sees no copy of itself: its own position is tied off and masked
  assign litsExp      = {qState, 1'b0, expIn, busIn};
  assign expRowMasked = termRows[EXP_ROW] & ~(ROW_W'(2'b11) << (2 * OWN_EXP_LIT));
  assign litsMain     = {qState, expOwn, expIn, busIn};

  genvar k;
  generate
    for (k = 0; k < TERM_ROWS; k++) begin : g_term
      if (k == EXP_ROW) begin : g_exp
        mcell_term #(.NUM_LIT(NUM_LIT)) u_term (
          .row  (expRowMasked),
          .lits (litsExp),
          .prod (termProd[k]),
          .used (termUsed[k])
        );
      end else begin : g_main
        mcell_term #(.NUM_LIT(NUM_LIT)) u_term (
          .row  (termRows[k]),
          .lits (litsMain),
          .prod (termProd[k]),
          .used (termUsed[k])
        );
      end
    end
  endgenerate

  // Inverted product, shared with neighbours and reused locally
  assign expOwn = ~termProd[EXP_ROW];
  assign expOut = expOwn;

  // Empty terms are inactive in the sum and for control functions
  assign sumAct     = termProd[NUM_SUM-1:0] & termUsed[NUM_SUM-1:0];
  assign presetAct  = termProd[PRE_ROW] & termUsed[PRE_ROW];
  assign clearAct   = termProd[CLR_ROW] & termUsed[CLR_ROW];
  assign clkTermAct = termProd[CLK_ROW] & termUsed[CLK_ROW];

  always_comb begin
    orIn = sumAct;
    if (mode.xorTerm) orIn[0] = 1'b0;
  end

  assign dNext = (|orIn) ^ mode.invert ^ (mode.xorTerm & sumAct[0]);

  assign regClk = mode.termClk ? clkTermAct : clk;

  always_ff @(posedge regClk or negedge rstN or posedge presetAct or posedge clearAct) begin
    if (!rstN)          qState <= 1'b0;
    else if (presetAct) qState <= 1'b1;
    else if (clearAct)  qState <= 1'b0;
    else                qState <= dNext;
  end

  assign cellOut = mode.regOut ? qState : dNext;

endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell
  import mcell_pkg::*;
#(
  parameter int NUM_BUS = 8,
  parameter int NUM_EXP = 2,
  parameter int NUM_SUM = 3,
  localparam int NUM_LIT   = NUM_BUS + NUM_EXP + 2,
  localparam int ROW_W     = 2 * NUM_LIT,
  localparam int TERM_ROWS = NUM_SUM + 4,
  localparam int NUM_ROWS  = TERM_ROWS + 1,
  localparam int ADDR_W    = $clog2(NUM_ROWS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [ROW_W-1:0]   cfgData,
  input  logic [NUM_BUS-1:0] busIn,
  input  logic [NUM_EXP-1:0] expIn,
  output logic               cellOut,
  output logic               globalFb,
  output logic               expOut
);

  logic [TERM_ROWS-1:0][ROW_W-1:0] termRows;
  modeCfg_t mode;
  logic     qState;
  logic     dNext;
  logic     presetAct;
  logic     clearAct;
  logic     clkTermAct;
  logic     termClkMode;
  logic     cellVal;

  mcell_cfg #(.ROW_W(ROW_W), .TERM_ROWS(TERM_ROWS), .ADDR_W(ADDR_W)) u_cfg (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .termRows (termRows),
    .mode     (mode)
  );

  mcell_dp #(.NUM_BUS(NUM_BUS), .NUM_EXP(NUM_EXP), .NUM_SUM(NUM_SUM)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .termRows   (termRows),
    .mode       (mode),
    .busIn      (busIn),
    .expIn      (expIn),
    .cellOut    (cellVal),
    .expOut     (expOut),
    .qState     (qState),
    .dNext      (dNext),
    .presetAct  (presetAct),
    .clearAct   (clearAct),
    .clkTermAct (clkTermAct)
  );

  assign termClkMode = mode.termClk;
  assign cellOut     = cellVal;
  assign globalFb    = cellVal;

endmodule

// File: rtl/pterm_macrocell_chk.sv
module pterm_macrocell_chk (
  input logic clk,
  input logic rstN,
  input logic qState,
  input logic dNext,
  input logic presetAct,
  input logic clearAct,
  input logic clkTermAct,
  input logic termClkMode
);

  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rstN)
    presetAct |-> qState); // R8

  AST_CLEAR_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    (clearAct && !presetAct) |-> !qState); // R9

  AST_PRESET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (presetAct && clearAct) |-> qState); // R9

  AST_SYS_CLK_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!termClkMode && !presetAct && !clearAct)
     && !termClkMode && !presetAct && !clearAct) |-> (qState == $past(dNext))); // R5

  AST_TERM_CLK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN && termClkMode && !clkTermAct && !presetAct && !clearAct)
     && termClkMode && !clkTermAct && !presetAct && !clearAct) |-> $stable(qState)); // R10

endmodule

bind pterm_macrocell pterm_macrocell_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .qState      (qState),
  .dNext       (dNext),
  .presetAct   (presetAct),
  .clearAct    (clearAct),
  .clkTermAct  (clkTermAct),
  .termClkMode (termClkMode)
);

// File: tb/pterm_macrocell_bench.sv
module pterm_macrocell_bench;

  localparam int NB    = 8;
  localparam int NE    = 2;
  localparam int NLIT  = NB + NE + 2;
  localparam int ROW_W = 2 * NLIT;
  localparam int OWNX  = NB + NE;
  localparam int FBL   = NB + NE + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWe = 1'b0;
  logic [2:0]       cfgAddr = '0;
  logic [ROW_W-1:0] cfgData = '0;
  logic [NB-1:0]    busIn = '0;
  logic [NE-1:0]    expIn = '0;
  logic             cellOut, globalFb, expOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pterm_macrocell u_pterm_macrocell (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .busIn(busIn), .expIn(expIn), .cellOut(cellOut), .globalFb(globalFb), .expOut(expOut)
  );

  always #4 clk = ~clk;

  // {bus, expIn, expected cellOut, expected expOut}
  // eq: b0&b1 | ~b2&b3 | x0 ; expander = ~(b4&b5)
  localparam logic [11:0] VEC [0:7] = '{
    {8'h00, 2'b00, 1'b0, 1'b1},
    {8'h03, 2'b00, 1'b1, 1'b1},
    {8'h08, 2'b00, 1'b1, 1'b1},
    {8'h0C, 2'b00, 1'b0, 1'b1},
    {8'h00, 2'b01, 1'b1, 1'b1},
    {8'h01, 2'b00, 1'b0, 1'b1},
    {8'h0F, 2'b00, 1'b1, 1'b1},
    {8'hF4, 2'b10, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic writeRow(input logic [2:0] a, input logic [ROW_W-1:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0; cfgData = '0;
  endtask

  task automatic setIn(input logic [NB-1:0] b, input logic [NE-1:0] x);
    @(negedge clk);
    busIn = b; expIn = x;
    #1;
  endtask

  function automatic logic [1:0] evalTerm(input logic [ROW_W-1:0] row, input logic [NLIT-1:0] l);
    logic p = 1'b1;
    logic u = 1'b0;
    for (int i = 0; i < NLIT; i++) begin
      if (row[2*i +: 2] != 2'b00) u = 1'b1;
      if (row[2*i +: 2] == 2'b01) p = p & l[i];
      if (row[2*i +: 2] == 2'b10) p = p & ~l[i];
      if (row[2*i +: 2] == 2'b11) p = 1'b0;
    end
    return {u, p};
  endfunction

  function automatic logic [ROW_W-1:0] randRow();
    logic [ROW_W-1:0] r = '0;
    for (int i = 0; i < NLIT; i++) begin
      int v = int'($urandom % 8);
      r[2*i +: 2] = (v < 5) ? 2'b00 : (v == 5) ? 2'b01 : (v == 6) ? 2'b10 : 2'b11;
    end
    return r;
  endfunction

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // R12: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R12 cellOut in reset", cellOut, 1'b0);
    chk("R12 expOut in reset", expOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R12 cellOut after reset", cellOut, 1'b0);
    chk("R12 globalFb after reset", globalFb, 1'b0);

    // R1 R2 R6: fixed equation table
    writeRow(3'd0, 24'h000005);
    writeRow(3'd1, 24'h000060);
    writeRow(3'd2, 24'h010000);
    writeRow(3'd6, 24'h000500);
    writeRow(3'd7, 24'h0);
    for (int v = 0; v < 8; v++) begin
      setIn(VEC[v][11:4], VEC[v][3:2]);
      chk("R2 table cellOut", cellOut, VEC[v][1]);
      chk("R6 table expOut", expOut, VEC[v][0]);
      chk("R5 table globalFb", globalFb, VEC[v][1]);
    end

    // R3: polarity
    writeRow(3'd7, 24'h1);
    setIn(8'h03, 2'b00); chk("R3 inverted true sum", cellOut, 1'b0);
    setIn(8'h00, 2'b00); chk("R3 inverted false sum", cellOut, 1'b1);

    // R4: term 0 moved to XOR
    writeRow(3'd7, 24'h8);
    setIn(8'h0B, 2'b00); chk("R4 both sides 1", cellOut, 1'b0);
    setIn(8'h03, 2'b00); chk("R4 xor term only", cellOut, 1'b1);
    setIn(8'h08, 2'b00); chk("R4 or side only", cellOut, 1'b1);

    // R1: kill code
    writeRow(3'd7, 24'h0);
    writeRow(3'd1, 24'h0);
    writeRow(3'd2, 24'h0);
    writeRow(3'd0, 24'h000003);
    setIn(8'h01, 2'b00); chk("R1 code 11 forces term false", cellOut, 1'b0);
    // R2: all empty sum rows
    writeRow(3'd0, 24'h0);
    setIn(8'hFF, 2'b11); chk("R2 empty terms give 0", cellOut, 1'b0);

    // R6: chaining own expander, own literal ignored in expander row
    writeRow(3'd0, 24'h100000);
    writeRow(3'd6, 24'h100500);
    setIn(8'h30, 2'b00);
    chk("R6 expander low", expOut, 1'b0);
    chk("R6 chained sum low", cellOut, 1'b0);
    setIn(8'h10, 2'b00);
    chk("R6 expander high", expOut, 1'b1);
    chk("R6 chained sum high", cellOut, 1'b1);
    writeRow(3'd6, 24'h0);
    setIn(8'hFF, 2'b11); chk("R6 empty expander gives 0", expOut, 1'b0);

    // R5: registered output
    setIn(8'h00, 2'b00);
    writeRow(3'd0, 24'h000001);
    writeRow(3'd7, 24'h2);
    setIn(8'h01, 2'b00);
    chk("R5 registered not transparent", cellOut, 1'b0);
    @(posedge clk); #1;
    chk("R5 registered after edge", cellOut, 1'b1);
    chk("R5 globalFb registered", globalFb, 1'b1);
    setIn(8'h00, 2'b00);
    @(posedge clk); #1;
    chk("R5 registered falls", cellOut, 1'b0);

    // R7: toggle through local feedback
    writeRow(3'd0, 24'h800000);
    @(posedge clk); #1; chk("R7 toggle to 1", cellOut, 1'b1);
    @(posedge clk); #1; chk("R7 toggle to 0", cellOut, 1'b0);

    // R8 R9: product-term set and clear
    writeRow(3'd0, 24'h0);
    writeRow(3'd3, 24'h001000);
    writeRow(3'd4, 24'h004000);
    setIn(8'h40, 2'b00); chk("R8 set acts before edge", cellOut, 1'b1);
    setIn(8'h80, 2'b00); chk("R9 clear acts before edge", cellOut, 1'b0);
    setIn(8'hC0, 2'b00); chk("R9 set wins over clear", cellOut, 1'b1);
    setIn(8'h00, 2'b00);
    @(posedge clk); #1; chk("R8 released set reloads d", cellOut, 1'b0);

    // R10: product-term clock
    writeRow(3'd3, 24'h0);
    writeRow(3'd4, 24'h0);
    writeRow(3'd0, 24'h000001);
    writeRow(3'd5, 24'h000400);
    writeRow(3'd7, 24'h6);
    setIn(8'h01, 2'b00);
    @(posedge clk); @(posedge clk); #1;
    chk("R10 system edges ignored", cellOut, 1'b0);
    setIn(8'h21, 2'b00); chk("R10 term clock rise loads", cellOut, 1'b1);
    setIn(8'h20, 2'b00);
    @(posedge clk); #1; chk("R10 no new rise holds", cellOut, 1'b1);
    setIn(8'h00, 2'b00);
    setIn(8'h20, 2'b00); chk("R10 second rise loads 0", cellOut, 1'b0);

    // R11: write enable low
    writeRow(3'd7, 24'h0);
    setIn(8'h01, 2'b00);
    @(negedge clk);
    cfgAddr = 3'd0; cfgData = '0; cfgWe = 1'b0;
    @(posedge clk); @(negedge clk); #1;
    chk("R11 no write without enable", cellOut, 1'b1);

    // R12: reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R12 mid-run reset output", cellOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R12 configuration cleared", cellOut, 1'b0);

    // R1 R2 R3 R4 R6: random equations against bench model
    for (int it = 0; it < 150; it++) begin
      logic [ROW_W-1:0] fbMask;
      logic [ROW_W-1:0] s0, s1, s2, ex;
      logic inv, xt;
      fbMask = ~(ROW_W'(2'b11) << (2*FBL));
      s0 = randRow() & fbMask;
      s1 = randRow() & fbMask;
      s2 = randRow() & fbMask;
      ex = randRow() & fbMask;
      inv = 1'($urandom % 2);
      xt  = 1'($urandom % 2);
      writeRow(3'd0, s0);
      writeRow(3'd1, s1);
      writeRow(3'd2, s2);
      writeRow(3'd6, ex);
      writeRow(3'd7, {20'h0, xt, 2'b00, inv});
      for (int j = 0; j < 4; j++) begin
        logic [NB-1:0] b;
        logic [NE-1:0] x;
        logic [NLIT-1:0] l;
        logic [1:0] t0, t1, t2, te;
        logic eo, a0, orv, dv;
        b = NB'($urandom);
        x = NE'($urandom);
        te = evalTerm(ex & ~(ROW_W'(2'b11) << (2*OWNX)), {1'b0, 1'b0, x, b});
        eo = ~te[0];
        l = {1'b0, eo, x, b};
        t0 = evalTerm(s0, l);
        t1 = evalTerm(s1, l);
        t2 = evalTerm(s2, l);
        a0 = t0[1] & t0[0];
        orv = (t1[1] & t1[0]) | (t2[1] & t2[0]) | (xt ? 1'b0 : a0);
        dv = orv ^ inv ^ (xt & a0);
        setIn(b, x);
        chk("R6 random expander", expOut, eo);
        chk("R2 random sum of products", cellOut, dv);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule